// File: doc/BRIEF.md
# Minimal 32-bit message-port processor core

This block is a small single-issue, multicycle 32-bit processor. It fetches fixed 32-bit instruction words and runs them one at a time over a fetch, execute and optional memory or message phase. It supports twelve operations: register add, add-immediate, multiply, word load, word store, absolute jump, jump-and-link, register jump, branch-if-not-equal, no-op, and two coprocessor-style moves. The coprocessor-style moves do not reach any system register. They pass words to and from a test manager over a pair of message streams. There are 32 general registers and no separate product registers. Control transfers take effect at once, so no instruction runs after a jump or a taken branch before the target.

Each external path is a valid/ready stream, and each transfer completes on a rising clock edge where valid and ready are both high. A source holds valid and its payload steady until that edge. The core has at most one request, response or message transfer open at any time. It holds a request until that request is accepted, and it keeps its response ready high until the response arrives. A slow instruction memory, data memory or manager therefore only adds stall cycles and never changes a result. Addresses are byte addresses and words are little-endian. Memory returns one response word per request, and a store also waits for its response before the core moves on.

Top module: `mc_core`

## Requirements
- R1: While reset (synchronous, active high) is asserted and in the first cycle after it, the core presents an instruction fetch for address 0. All registers read zero, and no data request, outgoing message or input-ready is active.
- R2: Every request (`imem_req_*`, `dmem_req_*`, `mgr_out_*`) keeps valid and payload steady until accepted. At most one of imem request valid, data request valid, outgoing message valid and input ready is high at a time. Stalls on any port never change the architectural result.
- R3: Opcode 0 with function 0x21 writes rs+rt into rd. Opcode 0x09 writes rs plus the sign-extended 16-bit immediate into rt. Both wrap modulo 2^32 and never trap. Fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0], immediate [15:0].
- R4: Opcode 0x1C with function 0x02 writes the low 32 bits of rs*rt into rd.
- R5: Register 0 always reads zero, and every write to it is dropped.
- R6: A load (opcode 0x23) writes the word at rs+sext(imm) into rt. A store (opcode 0x2B) writes rt to that address. Both use byte addresses, and a store completes only on its response.
- R7: A branch (opcode 0x05) with rs!=rt continues at PC+4+(sext(imm)<<2). Otherwise it continues at PC+4. No delay slot follows a taken branch.
- R8: A jump (opcode 0x02) or jump-and-link (opcode 0x03) continues at {PC+4[31:28], index[25:0], 2'b00}. Jump-and-link also writes PC+4 into register 31. No delay slot follows either one.
- R9: A register jump (opcode 0, function 0x08) continues at the value of rs.
- R10: Opcode 0x10 with rs field 4 and rd field 21 sends the value of rt as one outgoing message, waiting for ready.
- R11: Opcode 0x10 with rs field 0 and rd field 20 takes the next input message into rt, waiting for valid.
- R12: Any other encoding, including coprocessor moves with other rs or rd values, acts as a no-op. Such an instruction moves to PC+4 with no register write, memory access or message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_req_valid | output | 1 | Instruction fetch request valid |
| imem_req_ready | input | 1 | Instruction memory accepts the fetch |
| imem_req_addr | output | 32 | Fetch byte address |
| imem_resp_valid | input | 1 | Instruction word valid |
| imem_resp_ready | output | 1 | Core accepts the instruction word |
| imem_resp_data | input | 32 | Instruction word |
| dmem_req_valid | output | 1 | Data request valid |
| dmem_req_ready | input | 1 | Data memory accepts the request |
| dmem_req_write | output | 1 | 1 for store, 0 for load |
| dmem_req_addr | output | 32 | Data byte address |
| dmem_req_wdata | output | 32 | Store data |
| dmem_resp_valid | input | 1 | Data response valid |
| dmem_resp_ready | output | 1 | Core accepts the data response |
| dmem_resp_rdata | input | 32 | Load data (ignored for a store) |
| mgr_out_valid | output | 1 | Outgoing manager message valid |
| mgr_out_ready | input | 1 | Manager accepts the message |
| mgr_out_data | output | 32 | Outgoing message word |
| mgr_in_valid | input | 1 | Incoming manager message valid |
| mgr_in_ready | output | 1 | Core takes the incoming message |
| mgr_in_data | input | 32 | Incoming message word |

## Verification
Directed sequences use operands at the edge of the value range: all-ones plus the largest positive value, and a negative immediate. These show whether the add wraps, whether the immediate is sign-extended and whether the product is truncated. A store to a negative displacement followed by a load reads back the data path through memory. Taken, not-taken and backward branches, together with skipped words after each kind of jump, show whether delay slots or wrong targets exist. A block of constrained random arithmetic, load and store traffic runs under random ready and valid timing on all four streams. Its outgoing messages and final data memory are compared with a reference model in the bench, which shows whether stalls corrupt state or reorder effects.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned REGS    = 32;
  localparam int unsigned RIDX    = $clog2(REGS);
  localparam logic [RIDX-1:0] LINK_REG = RIDX'(REGS - 1);

  localparam logic [5:0] OPC_SPECIAL  = 6'h00;
  localparam logic [5:0] OPC_SPECIAL2 = 6'h1C;
  localparam logic [5:0] OPC_JMP      = 6'h02;
  localparam logic [5:0] OPC_JAL      = 6'h03;
  localparam logic [5:0] OPC_BNE      = 6'h05;
  localparam logic [5:0] OPC_ADDI     = 6'h09;
  localparam logic [5:0] OPC_COP      = 6'h10;
  localparam logic [5:0] OPC_LDW      = 6'h23;
  localparam logic [5:0] OPC_STW      = 6'h2B;
  localparam logic [5:0] FN_ADD       = 6'h21;
  localparam logic [5:0] FN_JR        = 6'h08;
  localparam logic [5:0] FN_MUL       = 6'h02;
  localparam logic [4:0] COP_FROM     = 5'd0;
  localparam logic [4:0] COP_TO       = 5'd4;

  typedef enum logic [3:0] {
    OP_NOP, OP_ADD, OP_ADDI, OP_MUL, OP_LDW, OP_STW,
    OP_JMP, OP_JAL, OP_JR, OP_BNE, OP_MSGIN, OP_MSGOUT
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [RIDX-1:0]  rs;
    logic [RIDX-1:0]  rt;
    logic [RIDX-1:0]  rd;
    logic [XLEN-1:0]  simm;
    logic [25:0]      jidx;
  } dec_t;

  typedef enum logic [2:0] {
    ST_FETCH, ST_IWAIT, ST_EXEC, ST_DREQ, ST_DWAIT, ST_SEND, ST_RECV
  } st_e;
endpackage

// File: rtl/mc_decode.sv
module mc_decode import mc_pkg::*; #(
  parameter logic [4:0] OUT_SEL = 5'd21,
  parameter logic [4:0] IN_SEL  = 5'd20
) (
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);
  logic [5:0] opc, fn;
  logic       unused_shamt;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];
  assign unused_shamt = ^instr[10:6];

  always_comb begin
    dec.rs   = instr[25:21];
    dec.rt   = instr[20:16];
    dec.rd   = instr[15:11];
    dec.simm = {{(XLEN-16){instr[15]}}, instr[15:0]};
    dec.jidx = instr[25:0];
    dec.op   = OP_NOP;
    case (opc)
      OPC_SPECIAL: begin
        if (fn == FN_ADD)     dec.op = OP_ADD;
        else if (fn == FN_JR) dec.op = OP_JR;
      end
      OPC_SPECIAL2: if (fn == FN_MUL) dec.op = OP_MUL;
      OPC_ADDI:     dec.op = OP_ADDI;
      OPC_LDW:      dec.op = OP_LDW;
      OPC_STW:      dec.op = OP_STW;
      OPC_JMP:      dec.op = OP_JMP;
      OPC_JAL:      dec.op = OP_JAL;
      OPC_BNE:      dec.op = OP_BNE;
      OPC_COP: begin
        if (instr[25:21] == COP_FROM && instr[15:11] == IN_SEL)
          dec.op = OP_MSGIN;
        else if (instr[25:21] == COP_TO && instr[15:11] == OUT_SEL)
          dec.op = OP_MSGOUT;
      end
      default: dec.op = OP_NOP;
    endcase
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned W    = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (rst)                            regs[i] <= '0;
        else if (we && wa == AW'(i))        regs[i] <= wd;
      end
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
endmodule

// File: rtl/mc_exec.sv
module mc_exec import mc_pkg::*; (
  input  dec_t             dec,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic             wb_en,
  output logic [RIDX-1:0]  wb_addr,
  output logic [XLEN-1:0]  wb_data,
  output logic [XLEN-1:0]  next_pc,
  output logic [XLEN-1:0]  mem_addr
);
  logic [XLEN-1:0] pc4, jtarget, btarget, prod;

  assign pc4      = pc + XLEN'(4);
  assign jtarget  = {pc4[XLEN-1:28], dec.jidx, 2'b00};
  assign btarget  = pc4 + (dec.simm << 2);
  assign prod     = a * b;
  assign mem_addr = a + dec.simm;

  always_comb begin
    wb_en   = 1'b0;
    wb_addr = dec.rd;
    wb_data = a + b;
    next_pc = pc4;
    case (dec.op)
      OP_ADD:  wb_en = 1'b1;
      OP_ADDI: begin wb_en = 1'b1; wb_addr = dec.rt; wb_data = a + dec.simm; end
      OP_MUL:  begin wb_en = 1'b1; wb_data = prod; end
      OP_JMP:  next_pc = jtarget;
      OP_JAL:  begin wb_en = 1'b1; wb_addr = LINK_REG; wb_data = pc4; next_pc = jtarget; end
      OP_JR:   next_pc = a;
      OP_BNE:  if (a != b) next_pc = btarget;
      default: ;
    endcase
  end
endmodule

// File: rtl/mc_core.sv
module mc_core import mc_pkg::*; #(
  parameter logic [4:0] MGR_OUT_SEL = 5'd21,
  parameter logic [4:0] MGR_IN_SEL  = 5'd20
) (
  input  logic            clk,
  input  logic            rst,
  output logic            imem_req_valid,
  input  logic            imem_req_ready,
  output logic [XLEN-1:0] imem_req_addr,
  input  logic            imem_resp_valid,
  output logic            imem_resp_ready,
  input  logic [XLEN-1:0] imem_resp_data,
  output logic            dmem_req_valid,
  input  logic            dmem_req_ready,
  output logic            dmem_req_write,
  output logic [XLEN-1:0] dmem_req_addr,
  output logic [XLEN-1:0] dmem_req_wdata,
  input  logic            dmem_resp_valid,
  output logic            dmem_resp_ready,
  input  logic [XLEN-1:0] dmem_resp_rdata,
  output logic            mgr_out_valid,
  input  logic            mgr_out_ready,
  output logic [XLEN-1:0] mgr_out_data,
  input  logic            mgr_in_valid,
  output logic            mgr_in_ready,
  input  logic [XLEN-1:0] mgr_in_data
);
  st_e             state;
  logic [XLEN-1:0] pc, ir;
  dec_t            dec;
  logic [XLEN-1:0] rs_val, rt_val;
  logic            ex_we;
  logic [RIDX-1:0] ex_wa;
  logic [XLEN-1:0] ex_wd, ex_next_pc, ex_mem_addr;
  logic            rf_we;
  logic [RIDX-1:0] rf_wa;
  logic [XLEN-1:0] rf_wd;

  mc_decode #(.OUT_SEL(MGR_OUT_SEL), .IN_SEL(MGR_IN_SEL)) u_dec (
    .instr(ir), .dec(dec)
  );

  mc_regfile #(.NREG(REGS), .W(XLEN)) u_rf (
    .clk(clk), .rst(rst), .ra_a(dec.rs), .ra_b(dec.rt),
    .rd_a(rs_val), .rd_b(rt_val), .we(rf_we), .wa(rf_wa), .wd(rf_wd)
  );

  mc_exec u_ex (
    .dec(dec), .pc(pc), .a(rs_val), .b(rt_val),
    .wb_en(ex_we), .wb_addr(ex_wa), .wb_data(ex_wd),
    .next_pc(ex_next_pc), .mem_addr(ex_mem_addr)
  );

  // Write-back source: execute result, load data or incoming message.
  always_comb begin
    rf_we = 1'b0;
    rf_wa = dec.rt;
    rf_wd = mgr_in_data;
    case (state)
      ST_EXEC:  begin rf_we = ex_we; rf_wa = ex_wa; rf_wd = ex_wd; end
      ST_DWAIT: begin rf_we = dmem_resp_valid && !dmem_req_write; rf_wd = dmem_resp_rdata; end
      ST_RECV:  rf_we = mgr_in_valid;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH;
      pc    <= '0;
      ir    <= '0;
    end else begin
      case (state)
        ST_FETCH: if (imem_req_ready) state <= ST_IWAIT;
        ST_IWAIT: if (imem_resp_valid) begin
          ir    <= imem_resp_data;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          case (dec.op)
            OP_LDW, OP_STW: state <= ST_DREQ;
            OP_MSGOUT:      state <= ST_SEND;
            OP_MSGIN:       state <= ST_RECV;
            default: begin
              pc    <= ex_next_pc;
              state <= ST_FETCH;
            end
          endcase
        end
        ST_DREQ:  if (dmem_req_ready) state <= ST_DWAIT;
        ST_DWAIT: if (dmem_resp_valid) begin pc <= ex_next_pc; state <= ST_FETCH; end
        ST_SEND:  if (mgr_out_ready)   begin pc <= ex_next_pc; state <= ST_FETCH; end
        ST_RECV:  if (mgr_in_valid)    begin pc <= ex_next_pc; state <= ST_FETCH; end
        default:  state <= ST_FETCH;
      endcase
    end
  end

  assign imem_req_valid  = (state == ST_FETCH);
  assign imem_req_addr   = pc;
  assign imem_resp_ready = (state == ST_IWAIT);
  assign dmem_req_valid  = (state == ST_DREQ);
  assign dmem_req_write  = (dec.op == OP_STW);
  assign dmem_req_addr   = ex_mem_addr;
  assign dmem_req_wdata  = rt_val;
  assign dmem_resp_ready = (state == ST_DWAIT);
  assign mgr_out_valid   = (state == ST_SEND);
  assign mgr_out_data    = rt_val;
  assign mgr_in_ready    = (state == ST_RECV);

  // R1
  reset_vec_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> imem_req_valid && imem_req_addr == '0 && !dmem_req_valid && !mgr_out_valid);
  // R2
  fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    imem_req_valid && !imem_req_ready |=> imem_req_valid && $stable(imem_req_addr));
  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_req_valid && !dmem_req_ready |=> dmem_req_valid && $stable(dmem_req_addr)
      && $stable(dmem_req_wdata) && $stable(dmem_req_write));
  // R2
  one_port_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({imem_req_valid, dmem_req_valid, mgr_out_valid, mgr_in_ready}));
  // R10
  msg_out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mgr_out_valid && !mgr_out_ready |=> mgr_out_valid && $stable(mgr_out_data));
  // R11
  msg_in_wait_chk: assert property (@(posedge clk) disable iff (rst)
    mgr_in_ready && !mgr_in_valid |=> mgr_in_ready);
endmodule

// File: tb/test_mc_core.sv
module test_mc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_req_valid, imem_req_ready, imem_resp_valid, imem_resp_ready;
  logic [31:0] imem_req_addr, imem_resp_data;
  logic        dmem_req_valid, dmem_req_ready, dmem_req_write, dmem_resp_valid, dmem_resp_ready;
  logic [31:0] dmem_req_addr, dmem_req_wdata, dmem_resp_rdata;
  logic        mgr_out_valid, mgr_out_ready, mgr_in_valid, mgr_in_ready;
  logic [31:0] mgr_out_data, mgr_in_data;

  always #10 clk = ~clk;

  mc_core i_mc_core (.*);

  logic [31:0] imem [128];
  logic [31:0] dmem [64];
  logic [31:0] mm   [64];
  logic [31:0] rr   [32];
  string       itag [128];
  logic [31:0] in_vals [8];
  logic [31:0] exp_val [64];
  string       exp_tag [64];
  int n_exp = 0, n_got = 0, n_chk = 0, n_err = 0, k = 0, cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] opc, input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {opc, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] opc, input int rs, input int rt, input logic [15:0] imm);
    return {opc, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [5:0] opc, input int widx);
    return {opc, 26'(widx)};
  endfunction

  task automatic put(input logic [31:0] w, input string tag);
    imem[k] = w; itag[k] = tag; k++;
  endtask
  task automatic msg_in(input int rt);  put({6'h10, 5'd0, 5'(rt), 5'd20, 11'd0}, ""); endtask
  task automatic msg_out(input int rt, input string tag); put({6'h10, 5'd4, 5'(rt), 5'd21, 11'd0}, tag); endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] v);
    if (idx != 0) rr[idx] = v;
  endtask

  // Reference model built from the requirements.
  task automatic run_iss();
    logic [31:0] pc, w, pc4, si, nxt, jt, a, b;
    int inp = 0;
    pc = 0;
    for (int s = 0; s < 5000; s++) begin
      w = imem[pc[8:2]];
      pc4 = pc + 4; nxt = pc4;
      si = {{16{w[15]}}, w[15:0]};
      jt = {pc4[31:28], w[25:0], 2'b00};
      a = rr[w[25:21]]; b = rr[w[20:16]];
      if (w[31:26] == 6'h02 && jt == pc) break;
      case (w[31:26])
        6'h00: if (w[5:0] == 6'h21) wr(w[15:11], a + b); else if (w[5:0] == 6'h08) nxt = a;
        6'h1C: if (w[5:0] == 6'h02) wr(w[15:11], a * b);
        6'h09: wr(w[20:16], a + si);
        6'h23: wr(w[20:16], mm[6'((a + si) >> 2)]);
        6'h2B: mm[6'((a + si) >> 2)] = b;
        6'h02: nxt = jt;
        6'h03: begin wr(5'd31, pc4); nxt = jt; end
        6'h05: if (a != b) nxt = pc4 + (si << 2);
        6'h10: begin
          if (w[25:21] == 5'd0 && w[15:11] == 5'd20) begin wr(w[20:16], in_vals[inp]); inp++; end
          else if (w[25:21] == 5'd4 && w[15:11] == 5'd21) begin
            exp_val[n_exp] = b; exp_tag[n_exp] = itag[pc[8:2]]; n_exp++;
          end
        end
        default: ;
      endcase
      pc = nxt;
    end
  endtask

  task automatic build();
    int m;
    for (int i = 0; i < 128; i++) begin imem[i] = 32'd0; itag[i] = ""; end
    for (int i = 0; i < 64; i++) begin dmem[i] = $urandom; mm[i] = dmem[i]; end
    for (int i = 0; i < 32; i++) rr[i] = 32'd0;
    for (int i = 0; i < 8; i++) in_vals[i] = $urandom;
    in_vals[6] = 32'hFFFF_FFFF; in_vals[7] = 32'h7FFF_FFFF;
    for (int i = 1; i <= 8; i++) msg_in(i);
    msg_out(1, "R11 input message"); msg_out(2, "R11 input message");
    put({6'h10, 5'd0, 5'd9, 5'd3, 11'd0}, "");                // wrong selector: no-op
    msg_out(9, "R12 ignored move/no input taken");
    put(32'hFFFF_FFFF, "");                                   // unknown opcode
    put({6'h10, 5'd4, 5'd1, 5'd3, 11'd0}, "");                // wrong selector: no message
    put(enc_r(6'h00, 7, 8, 15, 6'h21), ""); msg_out(15, "R3 add wraps");
    put(enc_i(6'h09, 8, 16, 16'h0001), ""); msg_out(16, "R3 addi wraps");
    put(enc_i(6'h09, 1, 17, 16'hFFFD), ""); msg_out(17, "R3 addi sign-extends");
    put(enc_r(6'h1C, 7, 8, 18, 6'h02), ""); msg_out(18, "R4 mul low word");
    put(enc_r(6'h1C, 1, 2, 19, 6'h02), ""); msg_out(19, "R4 mul random");
    put(enc_i(6'h09, 1, 0, 16'h0005), ""); msg_out(0, "R5 r0 addi discarded");
    put(enc_r(6'h00, 1, 2, 0, 6'h21), ""); msg_out(0, "R5 r0 add discarded");
    put(enc_i(6'h09, 0, 20, 16'h0080), "");
    put(enc_i(6'h2B, 20, 1, 16'hFFFC), "");
    put(enc_i(6'h23, 20, 21, 16'hFFFC), ""); msg_out(21, "R6 store/load negative disp");
    put(enc_i(6'h23, 20, 22, 16'h0008), ""); msg_out(22, "R6 load preset word");
    for (int i = 0; i < 40; i++) begin
      int sel = $urandom % 5;
      int rs = $urandom % 9, rt = $urandom % 9, rd = $urandom % 9;
      case (sel)
        0: put(enc_r(6'h00, rs, rt, rd, 6'h21), "");
        1: put(enc_i(6'h09, rs, rt, 16'($urandom)), "");
        2: put(enc_r(6'h1C, rs, rt, rd, 6'h02), "");
        3: put(enc_i(6'h2B, 0, rt, 16'(4 * ($urandom % 64))), "");
        default: put(enc_i(6'h23, 0, rt, 16'(4 * ($urandom % 64))), "");
      endcase
    end
    for (int i = 0; i <= 8; i++) msg_out(i, "R2 R3 R4 R6 random mix");
    put(enc_i(6'h09, 0, 10, 16'h0000), "");
    put(enc_i(6'h05, 0, 0, 16'h0001), "");                    // not taken
    put(enc_i(6'h09, 10, 10, 16'h0001), "");
    put(enc_i(6'h09, 0, 11, 16'h0005), "");
    put(enc_i(6'h05, 11, 0, 16'h0001), "");                   // taken, skip one
    put(enc_i(6'h09, 10, 10, 16'h0010), "");
    msg_out(10, "R7 branch taken/not taken");
    put(enc_i(6'h09, 0, 13, 16'h0003), "");
    put(enc_i(6'h09, 0, 14, 16'h0000), "");
    m = k;
    put(enc_i(6'h09, 14, 14, 16'h0002), "");
    put(enc_i(6'h09, 13, 13, 16'hFFFF), "");
    put(enc_i(6'h05, 13, 0, 16'(m - (k + 1))), "");           // backward loop
    msg_out(14, "R7 backward branch loop");
    put(enc_j(6'h03, k + 3), "");
    put(enc_i(6'h09, 10, 10, 16'd100), "");
    put(enc_i(6'h09, 10, 10, 16'd100), "");
    msg_out(10, "R8 jal skips words"); msg_out(31, "R8 jal link value");
    put(enc_j(6'h02, k + 2), "");
    put(enc_i(6'h09, 10, 10, 16'd50), "");
    msg_out(10, "R8 jump skips word");
    put(enc_i(6'h09, 0, 12, 16'((k + 3) * 4)), "");
    put(enc_r(6'h00, 12, 0, 0, 6'h08), "");
    put(enc_i(6'h09, 10, 10, 16'd7), "");
    msg_out(10, "R9 register jump");
    put(enc_j(6'h02, k), "");                                 // park
  endtask

  // Instruction memory server with random stalls.
  initial begin
    logic [31:0] a;
    imem_req_ready = 0; imem_resp_valid = 0; imem_resp_data = 0;
    wait (!rst);
    forever begin
      @(negedge clk);
      imem_req_ready = ($urandom % 4) != 0;
      if (imem_req_valid && imem_req_ready) begin
        a = imem_req_addr;
        @(negedge clk); imem_req_ready = 0;
        repeat ($urandom % 3) @(negedge clk);
        imem_resp_data = imem[a[8:2]]; imem_resp_valid = 1;
        while (!imem_resp_ready) @(negedge clk);
        @(negedge clk); imem_resp_valid = 0;
      end
    end
  end

  // Data memory server with random stalls.
  initial begin
    logic [31:0] a;
    dmem_req_ready = 0; dmem_resp_valid = 0; dmem_resp_rdata = 0;
    wait (!rst);
    forever begin
      @(negedge clk);
      dmem_req_ready = ($urandom % 3) != 0;
      if (dmem_req_valid && dmem_req_ready) begin
        a = dmem_req_addr;
        if (dmem_req_write) dmem[a[7:2]] = dmem_req_wdata;
        @(negedge clk); dmem_req_ready = 0;
        repeat ($urandom % 3) @(negedge clk);
        dmem_resp_rdata = dmem_req_write ? 32'hDEAD_BEEF : dmem[a[7:2]];
        dmem_resp_valid = 1;
        while (!dmem_resp_ready) @(negedge clk);
        @(negedge clk); dmem_resp_valid = 0;
      end
    end
  end

  // Incoming message source.
  initial begin
    mgr_in_valid = 0; mgr_in_data = 0;
    wait (!rst);
    for (int i = 0; i < 8; i++) begin
      repeat (1 + $urandom % 3) @(negedge clk);
      mgr_in_data = in_vals[i]; mgr_in_valid = 1;
      while (!mgr_in_ready) @(negedge clk);
      @(negedge clk); mgr_in_valid = 0;
    end
  end

  // Outgoing message sink and comparison.
  initial begin
    mgr_out_ready = 0;
    wait (!rst);
    forever begin
      @(negedge clk);
      mgr_out_ready = ($urandom % 3) != 0;
      if (mgr_out_valid && mgr_out_ready) begin
        if (n_got < n_exp)
          chk(mgr_out_data == exp_val[n_got], exp_tag[n_got], mgr_out_data, exp_val[n_got]);
        else
          chk(1'b0, "R12 extra outgoing message", mgr_out_data, 32'd0);
        n_got++;
      end
    end
  end

  initial begin
    void'($urandom(32'd20250));
    build();
    run_iss();
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: first fetch from address 0, nothing else active
    chk(imem_req_valid && imem_req_addr == 0 && !dmem_req_valid && !mgr_out_valid && !mgr_in_ready,
        "R1 reset state", imem_req_addr, 32'd0);
    while (n_got < n_exp && cyc < 100000) @(negedge clk);
    if (cyc >= 100000) chk(1'b0, "watchdog expired", 32'(n_got), 32'(n_exp));
    repeat (60) @(negedge clk);
    chk(n_got == n_exp, "R10 R12 message count", 32'(n_got), 32'(n_exp));
    for (int i = 0; i < 64; i++) chk(dmem[i] == mm[i], "R6 final data memory", dmem[i], mm[i]);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule